// File: doc/BRIEF.md
# Pin Interrupt Aggregator with Selectable Request Split

This block watches 32 general-purpose input pins and turns activity on them into interrupt requests for a processor. Each pin has a 2-bit trigger condition: low level, high level, rising edge or falling edge. Each pin also has an override bit that makes any edge the trigger. A pin whose condition holds latches a status bit. Software clears that bit by writing a one to it. A per-pin enable mask decides which status bits count as pending.

The pending bits are gathered onto two registered request lines. A static mode input, `cfg_split`, selects how they are gathered:

- **Single mode** (`cfg_split` = 0): request 0 covers all 32 pins and request 1 stays low. This is the default integration.
- **Split mode** (`cfg_split` = 1): request 0 covers pins 15..0 and request 1 covers pins 31..16.

Software uses one register port for writes and reads. Each write is a single cycle. Reads are combinational from the address.

The pin inputs are asynchronous. They pass through two synchronizing flops. A third flop keeps the previous synchronized value so that edges can be detected. Reset is synchronous and active high.

The block has no multi-state control sequence. Its only named condition types are the four trigger kinds in R4 and the any-edge override in R5.

Top module: `gpio_irq_split`

## Requirements
- R1: A pin is pending when its status bit and its mask bit are both 1. A request output changes on the clock edge after the pending bits change. With mask 0, a set status bit raises no request.
- R2: When `cfg_split` = 1, `irq0_o` is the registered OR of pending bits 15..0, and `irq1_o` is the registered OR of pending bits 31..16.
- R3: When `cfg_split` = 0, `irq0_o` is the registered OR of all 32 pending bits, and `irq1_o` stays 0.
- R4: Each pin's trigger condition is a 2-bit code. Code 00 triggers on low level and 01 on high level. Code 10 triggers on a rising edge and 11 on a falling edge. These are judged on the synchronized pin against its previous synchronized value.
- R5: When the pin's bit in the edge-override register is 1 (parameter `EDGE_SEL_EN` = 1, the default), any change of the synchronized pin triggers, and the 2-bit code is ignored.
- R6: Writing to the status register clears every bit written as 1. Bits written as 0 keep their value.
- R7: If a pin triggers in the same cycle as a write that clears its status bit, the bit ends up set.
- R8: A change on `pin_in` reaches the synchronized value after two clock edges. A level trigger then sets status on the third edge. The request output follows on the fourth edge.
- R9: While `rst` is high at a clock edge, the following are all cleared to 0 at that edge: status, mask, edge-override, trigger codes and synchronizer flops. `irq0_o` and `irq1_o` are also driven 0.
- R10: The register addresses on the 3-bit address bus are fixed. Address 0 is status, 1 is mask and 2 is edge override. Address 3 holds the trigger codes for pins 15..0 and address 4 holds those for pins 31..16. In these two words, bits [2k+1:2k] are the code of the k-th pin of that half. A write lands on the next edge. `reg_rdata` shows the addressed register, and reads as 0 for addresses 5 to 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_split | input | 1 | Static mode select: 0 gives one combined request, 1 gives one request per 16-pin half |
| pin_in | input | 32 | Asynchronous pin levels |
| reg_we | input | 1 | Register write strobe, one write per cycle |
| reg_addr | input | 3 | Register select for writes and reads |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| irq0_o | output | 1 | Request 0: all pins, or pins 15..0 in split mode |
| irq1_o | output | 1 | Request 1: pins 31..16 in split mode, otherwise 0 |

## Verification
Each result has a fixed due time:

- A register write is visible on `reg_rdata` right after the edge that samples it.
- A request reacts one edge after the pending bits change.
- A pin change shows in status three edges after it is applied, and on a request line four edges after.

The bench drives inputs on falling edges. It keeps a behavioural model that advances on the same rising edge as the design. It compares `irq0_o`, `irq1_o` and `reg_rdata` against that model 1 ns after every rising edge. Each comparison carries a label that names the requirement the current stimulus exercises.

// File: rtl/gpio_irq_pkg.sv
`timescale 1ns/1ps
package gpio_irq_pkg;

    localparam int unsigned ADDR_W = 3;

    typedef enum logic [1:0] {
        TRIG_LOW  = 2'b00,
        TRIG_HIGH = 2'b01,
        TRIG_RISE = 2'b10,
        TRIG_FALL = 2'b11
    } trig_e;

    typedef enum logic [ADDR_W-1:0] {
        SEL_STATUS  = 3'd0,
        SEL_MASK    = 3'd1,
        SEL_EDGE    = 3'd2,
        SEL_TRIG_LO = 3'd3,
        SEL_TRIG_HI = 3'd4
    } reg_sel_e;

endpackage

// File: rtl/gpio_pin_sync.sv
`timescale 1ns/1ps
module gpio_pin_sync #(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] pin_i,
    output logic [W-1:0] sync_o,
    output logic [W-1:0] prev_o
);
    logic [W-1:0] meta_q;
    logic [W-1:0] sync_q;
    logic [W-1:0] prev_q;
    logic         hist_ok_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q    <= '0;
            sync_q    <= '0;
            prev_q    <= '0;
            hist_ok_q <= 1'b0;
        end else begin
            meta_q    <= pin_i;
            sync_q    <= meta_q;
            prev_q    <= sync_q;
            hist_ok_q <= 1'b1;
        end
    end

    assign sync_o = sync_q;
    assign prev_o = prev_q;

    // R8: the previous-value flop trails the synchronized value by one edge
    p_prev_trails_r8: assert property (@(posedge clk) disable iff (rst)
        hist_ok_q |-> (prev_o == $past(sync_o)));

endmodule

// File: rtl/gpio_detect.sv
`timescale 1ns/1ps
module gpio_detect
    import gpio_irq_pkg::*;
#(
    parameter int unsigned W = 32
) (
    input  logic [W-1:0]   sync_i,
    input  logic [W-1:0]   prev_i,
    input  logic [2*W-1:0] trig_i,
    input  logic [W-1:0]   any_edge_i,
    output logic [W-1:0]   hit_o
);
    for (genvar g = 0; g < W; g++) begin : g_pin
        logic  cur;
        logic  old;
        logic  by_code;
        trig_e kind;

        assign cur  = sync_i[g];
        assign old  = prev_i[g];
        assign kind = trig_e'(trig_i[2*g +: 2]);

        always_comb begin
            unique case (kind)
                TRIG_LOW:  by_code = ~cur;
                TRIG_HIGH: by_code = cur;
                TRIG_RISE: by_code = cur & ~old;
                TRIG_FALL: by_code = ~cur & old;
            endcase
        end

        assign hit_o[g] = any_edge_i[g] ? (cur ^ old) : by_code;
    end

endmodule

// File: rtl/gpio_irq_regs.sv
`timescale 1ns/1ps
module gpio_irq_regs
    import gpio_irq_pkg::*;
#(
    parameter int unsigned W           = 32,
    parameter bit          EDGE_SEL_EN = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [W-1:0]      wdata_i,
    input  logic [W-1:0]      hit_i,
    output logic [W-1:0]      status_o,
    output logic [W-1:0]      mask_o,
    output logic [W-1:0]      edge_o,
    output logic [2*W-1:0]    trig_o,
    output logic [W-1:0]      rdata_o
);
    reg_sel_e     sel;
    logic [W-1:0] clr;
    logic [W-1:0] status_q;
    logic [W-1:0] mask_q;
    logic [W-1:0] edge_q;
    logic [W-1:0] trig_lo_q;
    logic [W-1:0] trig_hi_q;

    assign sel = reg_sel_e'(addr_i);
    assign clr = (we_i && sel == SEL_STATUS) ? wdata_i : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            status_q  <= '0;
            mask_q    <= '0;
            trig_lo_q <= '0;
            trig_hi_q <= '0;
        end else begin
            status_q <= (status_q & ~clr) | hit_i;
            if (we_i && sel == SEL_MASK)    mask_q    <= wdata_i;
            if (we_i && sel == SEL_TRIG_LO) trig_lo_q <= wdata_i;
            if (we_i && sel == SEL_TRIG_HI) trig_hi_q <= wdata_i;
        end
    end

    if (EDGE_SEL_EN) begin : g_edge
        always_ff @(posedge clk) begin
            if (rst)                          edge_q <= '0;
            else if (we_i && sel == SEL_EDGE) edge_q <= wdata_i;
        end
    end else begin : g_no_edge
        assign edge_q = '0;
    end

    always_comb begin
        case (sel)
            SEL_STATUS:  rdata_o = status_q;
            SEL_MASK:    rdata_o = mask_q;
            SEL_EDGE:    rdata_o = edge_q;
            SEL_TRIG_LO: rdata_o = trig_lo_q;
            SEL_TRIG_HI: rdata_o = trig_hi_q;
            default:     rdata_o = '0;
        endcase
    end

    assign status_o = status_q;
    assign mask_o   = mask_q;
    assign edge_o   = edge_q;
    assign trig_o   = {trig_hi_q, trig_lo_q};

    // R7: a trigger in the cycle of a clear leaves the bit set
    p_set_wins_r7: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((status_o & $past(hit_i)) == $past(hit_i)));

    // R6: a cleared bit with no trigger reads back as zero
    p_w1c_clears_r6: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((status_o & $past(clr & ~hit_i)) == '0));

    // R6: bits neither cleared nor triggered keep their value
    p_w1c_keeps_r6: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((status_o & $past(~clr & ~hit_i)) == ($past(status_o) & $past(~clr & ~hit_i))));

    // R9: reset empties status and mask
    p_reset_regs_r9: assert property (@(posedge clk)
        rst |=> (status_o == '0 && mask_o == '0 && edge_o == '0));

endmodule

// File: rtl/gpio_irq_out.sv
`timescale 1ns/1ps
module gpio_irq_out #(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         split_i,
    input  logic [W-1:0] pend_i,
    output logic         irq0_o,
    output logic         irq1_o
);
    localparam int unsigned HALF = W / 2;

    logic any_lo;
    logic any_hi;
    logic irq0_q;
    logic irq1_q;

    assign any_lo = |pend_i[HALF-1:0];
    assign any_hi = |pend_i[W-1:HALF];

    always_ff @(posedge clk) begin
        if (rst) begin
            irq0_q <= 1'b0;
            irq1_q <= 1'b0;
        end else if (split_i) begin
            irq0_q <= any_lo;
            irq1_q <= any_hi;
        end else begin
            irq0_q <= any_lo | any_hi;
            irq1_q <= 1'b0;
        end
    end

    assign irq0_o = irq0_q;
    assign irq1_o = irq1_q;

    // R3: in single mode request 1 never rises
    p_single_irq1_low_r3: assert property (@(posedge clk) disable iff (rst)
        !split_i |=> !irq1_o);

    // R9: reset drives both requests low
    p_reset_irq_r9: assert property (@(posedge clk)
        rst |=> (!irq0_o && !irq1_o));

endmodule

// File: rtl/gpio_irq_split.sv
`timescale 1ns/1ps
module gpio_irq_split
    import gpio_irq_pkg::*;
#(
    parameter int unsigned NUM_PINS    = 32,
    parameter bit          EDGE_SEL_EN = 1'b1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                cfg_split,
    input  logic [NUM_PINS-1:0] pin_in,
    input  logic                reg_we,
    input  logic [ADDR_W-1:0]   reg_addr,
    input  logic [NUM_PINS-1:0] reg_wdata,
    output logic [NUM_PINS-1:0] reg_rdata,
    output logic                irq0_o,
    output logic                irq1_o
);
    localparam int unsigned HALF = NUM_PINS / 2;

    logic [NUM_PINS-1:0]   sync_w;
    logic [NUM_PINS-1:0]   prev_w;
    logic [NUM_PINS-1:0]   hit_w;
    logic [NUM_PINS-1:0]   status_w;
    logic [NUM_PINS-1:0]   mask_w;
    logic [NUM_PINS-1:0]   edge_w;
    logic [2*NUM_PINS-1:0] trig_w;
    logic [NUM_PINS-1:0]   pend_w;

    gpio_pin_sync #(.W(NUM_PINS)) u_sync (
        .clk    (clk),
        .rst    (rst),
        .pin_i  (pin_in),
        .sync_o (sync_w),
        .prev_o (prev_w)
    );

    gpio_detect #(.W(NUM_PINS)) u_detect (
        .sync_i     (sync_w),
        .prev_i     (prev_w),
        .trig_i     (trig_w),
        .any_edge_i (edge_w),
        .hit_o      (hit_w)
    );

    gpio_irq_regs #(.W(NUM_PINS), .EDGE_SEL_EN(EDGE_SEL_EN)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .we_i     (reg_we),
        .addr_i   (reg_addr),
        .wdata_i  (reg_wdata),
        .hit_i    (hit_w),
        .status_o (status_w),
        .mask_o   (mask_w),
        .edge_o   (edge_w),
        .trig_o   (trig_w),
        .rdata_o  (reg_rdata)
    );

    assign pend_w = status_w & mask_w;

    gpio_irq_out #(.W(NUM_PINS)) u_out (
        .clk     (clk),
        .rst     (rst),
        .split_i (cfg_split),
        .pend_i  (pend_w),
        .irq0_o  (irq0_o),
        .irq1_o  (irq1_o)
    );

    // R1: request 0 only follows a pending bit of the previous cycle
    p_irq0_needs_pend_r1: assert property (@(posedge clk) disable iff (rst)
        irq0_o |-> $past(pend_w != '0));

    // R2: request 1 only follows an upper-half pending bit in split mode
    p_irq1_upper_r2: assert property (@(posedge clk) disable iff (rst)
        irq1_o |-> $past(cfg_split && (pend_w[NUM_PINS-1:HALF] != '0)));

endmodule

// File: tb/sim_gpio_irq_split.sv
`timescale 1ns/1ps
module sim_gpio_irq_split;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_split = 1'b0;
    logic [31:0] pin_in = '0;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq0_o;
    logic        irq1_o;

    int    checks = 0;
    int    errors = 0;
    int    cyc = 0;
    bit    done = 1'b0;
    string phase = "R9 reset";

    always #2.5 clk = ~clk;

    gpio_irq_split u0 (
        .clk       (clk),
        .rst       (rst),
        .cfg_split (cfg_split),
        .pin_in    (pin_in),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .irq0_o    (irq0_o),
        .irq1_o    (irq1_o)
    );

    // ---------------- behavioural reference ----------------
    logic [31:0] m_a, m_b, m_old, m_st, m_mk, m_ed, m_lo, m_hi;
    logic        m_i0, m_i1;

    function automatic logic [31:0] ref_hits(input logic [31:0] now, input logic [31:0] was,
                                             input logic [31:0] lo, input logic [31:0] hi,
                                             input logic [31:0] anyedge);
        logic [31:0] r;
        r = '0;
        for (int i = 0; i < 32; i++) begin
            int code;
            code = (i < 16) ? int'(lo[2*i +: 2]) : int'(hi[2*(i-16) +: 2]);
            if (anyedge[i])      r[i] = (now[i] != was[i]);
            else if (code == 0)  r[i] = (now[i] == 1'b0);
            else if (code == 1)  r[i] = (now[i] == 1'b1);
            else if (code == 2)  r[i] = (now[i] == 1'b1) && (was[i] == 1'b0);
            else                 r[i] = (now[i] == 1'b0) && (was[i] == 1'b1);
        end
        return r;
    endfunction

    function automatic logic [31:0] ref_read(input logic [2:0] a);
        case (a)
            3'd0: return m_st;
            3'd1: return m_mk;
            3'd2: return m_ed;
            3'd3: return m_lo;
            3'd4: return m_hi;
            default: return 32'h0;
        endcase
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_a <= '0; m_b <= '0; m_old <= '0;
            m_st <= '0; m_mk <= '0; m_ed <= '0; m_lo <= '0; m_hi <= '0;
            m_i0 <= 1'b0; m_i1 <= 1'b0;
        end else begin
            logic [31:0] clrbits, pend;
            clrbits = (reg_we && reg_addr == 3'd0) ? reg_wdata : 32'h0;
            pend    = m_st & m_mk;
            m_st  <= (m_st & ~clrbits) | ref_hits(m_b, m_old, m_lo, m_hi, m_ed);
            m_a   <= pin_in;
            m_b   <= m_a;
            m_old <= m_b;
            if (reg_we && reg_addr == 3'd1) m_mk <= reg_wdata;
            if (reg_we && reg_addr == 3'd2) m_ed <= reg_wdata;
            if (reg_we && reg_addr == 3'd3) m_lo <= reg_wdata;
            if (reg_we && reg_addr == 3'd4) m_hi <= reg_wdata;
            if (cfg_split) begin
                m_i0 <= (pend[15:0] != 0);
                m_i1 <= (pend[31:16] != 0);
            end else begin
                m_i0 <= (pend != 0);
                m_i1 <= 1'b0;
            end
        end
    end

    task automatic check(input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h (t=%0t)", phase, what, act, exp, $time);
        end
    endtask

    // compare 1 ns after each rising edge
    always @(posedge clk) begin
        #1;
        if (!done) begin
            check("irq0", {31'h0, irq0_o}, {31'h0, m_i0});
            check("irq1", {31'h0, irq1_o}, {31'h0, m_i1});
            check("rdata", reg_rdata, ref_read(reg_addr));
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc == 20000 && !done) begin
            done = 1'b1;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    // ---------------- stimulus ----------------
    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0; reg_wdata = '0;
    endtask

    task automatic do_reset(input logic split);
        @(negedge clk);
        rst = 1'b1; cfg_split = split; pin_in = '0;
        idle(3);
        rst = 1'b0;
    endtask

    task automatic look(input logic [2:0] a);
        @(negedge clk);
        reg_addr = a;
    endtask

    initial begin
        phase = "R9 reset";
        idle(3);
        @(negedge clk);
        check("reset status", reg_rdata, 32'h0);   // R9 directed
        check("reset irq0", {31'h0, irq0_o}, 32'h0);
        rst = 1'b0;

        // R10: write every register and read back, then unmapped addresses
        phase = "R10 regmap";
        wr(3'd1, 32'h1234_5678); look(3'd1);
        wr(3'd3, 32'h5555_5555); look(3'd3);
        wr(3'd4, 32'h5555_5555); look(3'd4);
        wr(3'd2, 32'h0000_0000); look(3'd2);
        look(3'd5); idle(1); look(3'd6); idle(1); look(3'd7); idle(1);
        wr(3'd1, 32'h0000_0000);

        // R1: mask zero keeps requests low while high-level status sets
        phase = "R1 masked";
        pin_in = 32'h0001_0001; idle(6); look(3'd0); idle(2);
        phase = "R1 unmask";
        wr(3'd1, 32'hFFFF_FFFF); idle(3);

        // R8: pipeline timing of a level trigger on one pin
        phase = "R8 latency";
        pin_in = 32'h0;
        wr(3'd0, 32'hFFFF_FFFF); idle(2);
        pin_in = 32'h8000_0000; idle(6);

        // R6: write-one-to-clear; zeros keep bits
        phase = "R6 w1c";
        pin_in = 32'h0;
        wr(3'd3, 32'hAAAA_AAAA); wr(3'd4, 32'hAAAA_AAAA);
        wr(3'd0, 32'h0000_0000); idle(2);
        wr(3'd0, 32'h0000_FFFF); idle(2);
        wr(3'd0, 32'hFFFF_0000); idle(3);

        // R4: rising and falling edge codes
        phase = "R4 rise";
        pin_in = 32'h00F0_000F; idle(5);
        pin_in = 32'h0; idle(5);
        wr(3'd0, 32'hFFFF_FFFF); idle(2);
        phase = "R4 fall";
        wr(3'd3, 32'hFFFF_FFFF); wr(3'd4, 32'hFFFF_FFFF);
        pin_in = 32'h0F00_0F00; idle(5);
        pin_in = 32'h0; idle(5);
        wr(3'd0, 32'hFFFF_FFFF); idle(2);
        phase = "R4 low";
        wr(3'd3, 32'h0000_0000); idle(5);
        wr(3'd3, 32'hFFFF_FFFF); wr(3'd0, 32'hFFFF_FFFF); idle(3);

        // R5: any-edge override on upper pins with code falling
        phase = "R5 anyedge";
        wr(3'd2, 32'hFFFF_0000);
        pin_in = 32'h0003_0000; idle(5);
        wr(3'd0, 32'hFFFF_FFFF); idle(3);
        pin_in = 32'h0; idle(5);
        wr(3'd2, 32'h0); wr(3'd0, 32'hFFFF_FFFF); idle(3);

        // R7: held high level with a clear every cycle keeps the bit set
        phase = "R7 setwins";
        wr(3'd3, 32'h5555_5555);
        pin_in = 32'h0000_0004; idle(4);
        for (int k = 0; k < 4; k++) wr(3'd0, 32'hFFFF_FFFF);
        look(3'd0); idle(3);
        pin_in = 32'h0; idle(4); wr(3'd0, 32'hFFFF_FFFF); idle(3);

        // R3: single mode, upper-half pending drives irq0 only
        phase = "R3 single";
        pin_in = 32'h4000_0000; idle(6);
        pin_in = 32'h0; idle(3); wr(3'd0, 32'hFFFF_FFFF); idle(3);

        // R2: split mode, each half to its own request
        phase = "R9 reset split";
        do_reset(1'b1);
        phase = "R2 split";
        wr(3'd3, 32'h5555_5555); wr(3'd4, 32'h5555_5555);
        wr(3'd1, 32'hFFFF_FFFF);
        pin_in = 32'h0020_0000; idle(6);
        pin_in = 32'h0020_0002; idle(6);
        pin_in = 32'h0000_0002; wr(3'd0, 32'hFFFF_0000); idle(5);
        pin_in = 32'h0; wr(3'd0, 32'hFFFF_FFFF); idle(4);
        wr(3'd1, 32'h0000_FFFF);
        pin_in = 32'h8000_0000; idle(6);

        phase = "R9 reset end";
        do_reset(1'b0);
        idle(2);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule